// File: doc/BRIEF.md
# ATA Task-File Register Decoder

This block sits on the device side of a parallel ATA link. It holds the task-file register bank and turns host register accesses into short event pulses for a separate protocol sequencer. Byte registers sit in the command block, with one 16-bit data word at offset 0. The control block holds the device-control register, which reads back as alternate status. Media access, DMA movement and protocol sequencing are handled outside the block.

When the host writes the command register, the opcode is classified in that same clock edge. The block latches the transfer class, the DMA direction, the starting 28-bit LBA and the total byte count. It also updates status and error for either acceptance or abort. The read-native-max command writes the last addressable sector back into the address registers. The sequencer can overwrite status and reload the data word through side inputs. It uses the event pulses to advance its own state.

Top module: `ata_taskfile_dec`

## Requirements
- R1: After reset:
  - error reads 0x01 and status reads 0x40 (only the ready bit, bit 6);
  - sector count, sector, cylinder low/high, drive/head and data read 0;
  - `irq_disable` and `srst_active` are 0.
- R2: Data register (command block offset 0):
  - A write stores all 16 bits of `host_wdata`.
  - A read returns the stored word, or the word most recently loaded through `sm_data_load`.
  - A write pulses `ev_data_wr` and a read pulses `ev_data_rd`, for one cycle, in the cycle after the access.
- R3: A read of command-block offset 7 returns status and pulses `ev_stat_rd` in the next cycle. A read of control-block offset 6 returns the same status value and raises no event.
- R4: A write to drive/head (command-block offset 6) pulses `ev_sel_wr` in the next cycle. A write to offset 1 (features) changes no register, and the error value read at offset 1 stays the same.
- R5: A command write (command-block offset 7) latches the opcode and pulses `ev_cmd_wr` in the next cycle. If the command is accepted:
  - status bit 7 (busy) is set;
  - bits 3 (data request), 5 (device fault) and 0 (error) are cleared;
  - error reads 0x00.
- R6: `xfer_class` is set from the opcode; unknown opcodes give class 0:
  - 0 (non-data): 0x10, 0x40, 0x70, 0x91, 0xC6, 0xE0, 0xE7, 0xEF, 0xF8;
  - 1 (PIO in): 0x20, 0xC4, 0xEC;
  - 2 (PIO out): 0x30, 0xC5;
  - 3 (DMA): 0xC8, 0xCA.
- R7: `xfer_bytes` depends on the command:
  - read, write and DMA commands: sector count × 512, where a count of 0 means 256 sectors (131072 bytes);
  - identify (0xEC): 512;
  - non-data and rejected commands: 0.
- R8: `start_lba` is {drive/head[3:0], cylinder high, cylinder low, sector}, taken when the command is written.
- R9: `dma_mem_wr` is 1 for the DMA read-from-media command (0xC8) and 0 for the DMA write-to-media command (0xCA).
- R10: A read, write or DMA command with drive/head bit 6 (LBA) clear is rejected in the same way as an unknown opcode.
- R11: A rejected command sets error to 0x04 (abort) and status to 0x41, and pulses `ev_cmd_err` together with `ev_cmd_wr`.
- R12: Read-native-max (0xF8) computes `capacity` − 1 and writes it back as follows:
  - bits 7:0 into sector;
  - bits 15:8 into cylinder low;
  - bits 23:16 into cylinder high;
  - bits 27:24 into drive/head[3:0], keeping drive/head[7:4].
- R13: Device-control write (control-block offset 6):
  - Bit 1 is latched into `irq_disable` on every such write.
  - Bit 2 set enters soft reset: `srst_active` = 1, status bit 7 set, `ev_srst_set` pulsed.
  - Bit 2 clear while in soft reset leaves it: `ev_srst_clr` is pulsed and the register bank returns to its R1 values.
  - Bit 2 clear outside soft reset raises no event.
- R14: `sm_stat_we` loads `sm_stat_val` into status in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_rd | input | 1 | One-cycle host register read strobe |
| host_wr | input | 1 | One-cycle host register write strobe |
| host_blk | input | 1 | 0 selects the command block, 1 the control block |
| host_addr | input | 3 | Register offset within the block |
| host_wdata | input | 16 | Write data; byte registers use bits 7:0 |
| host_rdata | output | 16 | Read data for the addressed register (combinational) |
| sm_data_load | input | 1 | Sequencer loads the next data word |
| sm_data_word | input | 16 | Word loaded into the data register |
| sm_stat_we | input | 1 | Sequencer writes status |
| sm_stat_val | input | 8 | Status value written |
| capacity | input | 28 | Device capacity in sectors |
| ev_data_rd | output | 1 | Data-register read event |
| ev_data_wr | output | 1 | Data-register write event |
| ev_stat_rd | output | 1 | Status read event |
| ev_sel_wr | output | 1 | Drive-select write event |
| ev_cmd_wr | output | 1 | Command write event |
| ev_cmd_err | output | 1 | Command rejected event |
| ev_srst_set | output | 1 | Soft reset entered |
| ev_srst_clr | output | 1 | Soft reset released |
| xfer_class | output | 2 | Latched transfer class of the last command |
| dma_mem_wr | output | 1 | DMA direction: 1 = device writes memory |
| start_lba | output | 28 | Latched starting LBA |
| xfer_bytes | output | 18 | Latched total byte count |
| irq_disable | output | 1 | Latched interrupt-disable control bit |
| srst_active | output | 1 | Soft reset in progress |

## Verification
The assertions assume the following about the inputs:
- `host_rd` and `host_wr` are never high in the same cycle, so at most one host event fires per cycle.
- A sequencer status write never lands in the same cycle as a command or control write.

The directed stimulus keeps to these limits:
- Each task drives exactly one strobe for one cycle and returns it low before the next access.
- Sequencer loads are issued from their own tasks, apart from host accesses.

// File: rtl/ata_tf_pkg.sv
package ata_tf_pkg;

   localparam int LBA_W = 28;

   typedef enum logic [1:0] {
      XF_NONE    = 2'd0,
      XF_PIO_IN  = 2'd1,
      XF_PIO_OUT = 2'd2,
      XF_DMA     = 2'd3
   } xfer_class_e;

   // status bits
   localparam int ST_BSY  = 7;
   localparam int ST_DRDY = 6;
   localparam int ST_DF   = 5;
   localparam int ST_DRQ  = 3;
   localparam int ST_ERR  = 0;

   localparam logic [7:0] STAT_IDLE  = 8'h40;
   localparam logic [7:0] STAT_ABORT = 8'h41;
   localparam logic [7:0] ERR_DIAG   = 8'h01;
   localparam logic [7:0] ERR_ABORT  = 8'h04;

   localparam int DRV_LBA  = 6;
   localparam int CTL_SRST = 2;
   localparam int CTL_NIEN = 1;

   // register offsets
   localparam logic [2:0] RA_DATA = 3'd0;
   localparam logic [2:0] RA_FEAT = 3'd1;
   localparam logic [2:0] RA_CNT  = 3'd2;
   localparam logic [2:0] RA_SEC  = 3'd3;
   localparam logic [2:0] RA_CYLL = 3'd4;
   localparam logic [2:0] RA_CYLH = 3'd5;
   localparam logic [2:0] RA_DRV  = 3'd6;
   localparam logic [2:0] RA_CMD  = 3'd7;
   localparam logic [2:0] RA_CTL  = 3'd6;

   typedef struct packed {
      logic        known;
      xfer_class_e cls;
      logic        needs_lba;
      logic        mem_wr;
      logic        ident;
      logic        max_native;
   } cmd_info_t;

endpackage

// File: rtl/ata_tf_classify.sv
module ata_tf_classify
   import ata_tf_pkg::*;
(
   input  logic [7:0] opcode,
   output cmd_info_t  info
);
   always_comb begin
      info = '{known: 1'b0, cls: XF_NONE, needs_lba: 1'b0,
               mem_wr: 1'b0, ident: 1'b0, max_native: 1'b0};
      case (opcode)
         8'h10, 8'h40, 8'h70, 8'h91, 8'hC6, 8'hE0, 8'hE7, 8'hEF:
            info.known = 1'b1;
         8'hF8: begin
            info.known      = 1'b1;
            info.max_native = 1'b1;
         end
         8'hEC: begin
            info.known = 1'b1;
            info.cls   = XF_PIO_IN;
            info.ident = 1'b1;
         end
         8'h20, 8'hC4: begin
            info.known     = 1'b1;
            info.cls       = XF_PIO_IN;
            info.needs_lba = 1'b1;
         end
         8'h30, 8'hC5: begin
            info.known     = 1'b1;
            info.cls       = XF_PIO_OUT;
            info.needs_lba = 1'b1;
         end
         8'hC8: begin
            info.known     = 1'b1;
            info.cls       = XF_DMA;
            info.needs_lba = 1'b1;
            info.mem_wr    = 1'b1;
         end
         8'hCA: begin
            info.known     = 1'b1;
            info.cls       = XF_DMA;
            info.needs_lba = 1'b1;
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/ata_tf_sizer.sv
module ata_tf_sizer
   import ata_tf_pkg::*;
#(
   parameter int SECTOR_BYTES = 512,
   localparam int SHIFT   = $clog2(SECTOR_BYTES),
   localparam int BYTES_W = 9 + SHIFT
)(
   input  cmd_info_t          info,
   input  logic [7:0]         count,
   input  logic [7:0]         sector,
   input  logic [7:0]         cyl_lo,
   input  logic [7:0]         cyl_hi,
   input  logic [3:0]         head,
   input  logic [LBA_W-1:0]   capacity,
   output logic [BYTES_W-1:0] byte_total,
   output logic [LBA_W-1:0]   lba,
   output logic [LBA_W-1:0]   max_lba
);
   logic [8:0] sectors;

   assign sectors = (count == 8'd0) ? 9'd256 : {1'b0, count};
   assign lba     = {head, cyl_hi, cyl_lo, sector};
   assign max_lba = capacity - LBA_W'(1);

   always_comb begin
      if (info.ident)
         byte_total = BYTES_W'(SECTOR_BYTES);
      else if (info.cls != XF_NONE)
         byte_total = BYTES_W'(sectors) << SHIFT;
      else
         byte_total = '0;
   end
endmodule

// File: rtl/ata_taskfile_dec.sv
module ata_taskfile_dec
   import ata_tf_pkg::*;
#(
   parameter int SECTOR_BYTES = 512,
   parameter bit STRICT_LBA   = 1'b1,
   localparam int SHIFT   = $clog2(SECTOR_BYTES),
   localparam int BYTES_W = 9 + SHIFT
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               host_rd,
   input  logic               host_wr,
   input  logic               host_blk,
   input  logic [2:0]         host_addr,
   input  logic [15:0]        host_wdata,
   output logic [15:0]        host_rdata,
   input  logic               sm_data_load,
   input  logic [15:0]        sm_data_word,
   input  logic               sm_stat_we,
   input  logic [7:0]         sm_stat_val,
   input  logic [LBA_W-1:0]   capacity,
   output logic               ev_data_rd,
   output logic               ev_data_wr,
   output logic               ev_stat_rd,
   output logic               ev_sel_wr,
   output logic               ev_cmd_wr,
   output logic               ev_cmd_err,
   output logic               ev_srst_set,
   output logic               ev_srst_clr,
   output logic [1:0]         xfer_class,
   output logic               dma_mem_wr,
   output logic [LBA_W-1:0]   start_lba,
   output logic [BYTES_W-1:0] xfer_bytes,
   output logic               irq_disable,
   output logic               srst_active
);
   initial begin
      if (SECTOR_BYTES < 2 || (SECTOR_BYTES & (SECTOR_BYTES - 1)) != 0)
         $fatal(1, "SECTOR_BYTES must be a power of two");
   end

   logic [15:0] data_q;
   logic [7:0]  err_q, cnt_q, sec_q, cyll_q, cylh_q, drv_q, stat_q, op_q;
   xfer_class_e cls_q;

   logic wr_cmd, rd_cmd, wr_ctl;
   assign wr_cmd = host_wr & ~host_blk;
   assign rd_cmd = host_rd & ~host_blk;
   assign wr_ctl = host_wr &  host_blk & (host_addr == RA_CTL);

   cmd_info_t          info;
   logic [BYTES_W-1:0] bytes_n;
   logic [LBA_W-1:0]   lba_n, max_n;
   logic               chs_bad, accept;

   ata_tf_classify u_cls (
      .opcode (host_wdata[7:0]),
      .info   (info)
   );

   ata_tf_sizer #(.SECTOR_BYTES(SECTOR_BYTES)) u_size (
      .info       (info),
      .count      (cnt_q),
      .sector     (sec_q),
      .cyl_lo     (cyll_q),
      .cyl_hi     (cylh_q),
      .head       (drv_q[3:0]),
      .capacity   (capacity),
      .byte_total (bytes_n),
      .lba        (lba_n),
      .max_lba    (max_n)
   );

   generate
      if (STRICT_LBA) begin : g_strict
         assign chs_bad = info.needs_lba & ~drv_q[DRV_LBA];
      end else begin : g_loose
         assign chs_bad = 1'b0;
      end
   endgenerate

   assign accept = info.known & ~chs_bad;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q <= '0;  err_q <= ERR_DIAG; cnt_q <= '0; sec_q <= '0;
         cyll_q <= '0;  cylh_q <= '0;      drv_q <= '0; stat_q <= STAT_IDLE;
         op_q <= '0;    cls_q <= XF_NONE;  dma_mem_wr <= 1'b0;
         start_lba <= '0; xfer_bytes <= '0;
         irq_disable <= 1'b0; srst_active <= 1'b0;
         ev_data_rd <= 1'b0; ev_data_wr <= 1'b0; ev_stat_rd <= 1'b0;
         ev_sel_wr <= 1'b0;  ev_cmd_wr <= 1'b0;  ev_cmd_err <= 1'b0;
         ev_srst_set <= 1'b0; ev_srst_clr <= 1'b0;
      end else begin
         ev_data_rd <= 1'b0; ev_data_wr <= 1'b0; ev_stat_rd <= 1'b0;
         ev_sel_wr <= 1'b0;  ev_cmd_wr <= 1'b0;  ev_cmd_err <= 1'b0;
         ev_srst_set <= 1'b0; ev_srst_clr <= 1'b0;

         if (sm_data_load) data_q <= sm_data_word;
         if (sm_stat_we)   stat_q <= sm_stat_val;

         if (wr_cmd) begin
            case (host_addr)
               RA_DATA: begin
                  data_q     <= host_wdata;
                  ev_data_wr <= 1'b1;
               end
               RA_FEAT: ;
               RA_CNT:  cnt_q  <= host_wdata[7:0];
               RA_SEC:  sec_q  <= host_wdata[7:0];
               RA_CYLL: cyll_q <= host_wdata[7:0];
               RA_CYLH: cylh_q <= host_wdata[7:0];
               RA_DRV: begin
                  drv_q     <= host_wdata[7:0];
                  ev_sel_wr <= 1'b1;
               end
               default: begin
                  op_q      <= host_wdata[7:0];
                  ev_cmd_wr <= 1'b1;
                  start_lba <= lba_n;
                  if (accept) begin
                     cls_q      <= info.cls;
                     dma_mem_wr <= info.mem_wr;
                     xfer_bytes <= bytes_n;
                     err_q      <= 8'h00;
                     stat_q     <= (stat_q | (8'h1 << ST_BSY)) &
                                   ~((8'h1 << ST_DRQ) | (8'h1 << ST_DF) | (8'h1 << ST_ERR));
                     if (info.max_native) begin
                        sec_q  <= max_n[7:0];
                        cyll_q <= max_n[15:8];
                        cylh_q <= max_n[23:16];
                        drv_q  <= {drv_q[7:4], max_n[27:24]};
                     end
                  end else begin
                     cls_q      <= XF_NONE;
                     dma_mem_wr <= 1'b0;
                     xfer_bytes <= '0;
                     err_q      <= ERR_ABORT;
                     stat_q     <= STAT_ABORT;
                     ev_cmd_err <= 1'b1;
                  end
               end
            endcase
         end

         if (rd_cmd) begin
            if (host_addr == RA_DATA) ev_data_rd <= 1'b1;
            if (host_addr == RA_CMD)  ev_stat_rd <= 1'b1;
         end

         if (wr_ctl) begin
            irq_disable <= host_wdata[CTL_NIEN];
            if (host_wdata[CTL_SRST]) begin
               srst_active    <= 1'b1;
               stat_q[ST_BSY] <= 1'b1;
               ev_srst_set    <= 1'b1;
            end else if (srst_active) begin
               srst_active <= 1'b0;
               ev_srst_clr <= 1'b1;
               data_q <= '0;  err_q <= ERR_DIAG; cnt_q <= '0; sec_q <= '0;
               cyll_q <= '0;  cylh_q <= '0;      drv_q <= '0; stat_q <= STAT_IDLE;
               op_q <= '0;    cls_q <= XF_NONE;  dma_mem_wr <= 1'b0;
               start_lba <= '0; xfer_bytes <= '0;
            end
         end
      end
   end

   assign xfer_class = cls_q;

   always_comb begin
      host_rdata = 16'h0000;
      if (host_blk) begin
         if (host_addr == RA_CTL) host_rdata = {8'h00, stat_q};
      end else begin
         case (host_addr)
            RA_DATA: host_rdata = data_q;
            RA_FEAT: host_rdata = {8'h00, err_q};
            RA_CNT:  host_rdata = {8'h00, cnt_q};
            RA_SEC:  host_rdata = {8'h00, sec_q};
            RA_CYLL: host_rdata = {8'h00, cyll_q};
            RA_CYLH: host_rdata = {8'h00, cylh_q};
            RA_DRV:  host_rdata = {8'h00, drv_q};
            default: host_rdata = {8'h00, stat_q};
         endcase
      end
   end
endmodule

// File: rtl/ata_tf_chk.sv
module ata_tf_chk
   import ata_tf_pkg::*;
#(
   parameter int SECTOR_BYTES = 512,
   localparam int BYTES_W = 9 + $clog2(SECTOR_BYTES)
)(
   input logic               clk,
   input logic               rst_n,
   input logic               host_rd,
   input logic               host_wr,
   input logic               host_blk,
   input logic [2:0]         host_addr,
   input logic               ev_data_rd,
   input logic               ev_data_wr,
   input logic               ev_stat_rd,
   input logic               ev_sel_wr,
   input logic               ev_cmd_wr,
   input logic               ev_cmd_err,
   input logic               ev_srst_set,
   input logic               ev_srst_clr,
   input logic [7:0]         stat_q,
   input logic [7:0]         err_q,
   input logic               srst_active,
   input logic [1:0]         xfer_class,
   input logic [BYTES_W-1:0] xfer_bytes
);
   a_r2_one_event: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({ev_data_rd, ev_data_wr, ev_stat_rd, ev_sel_wr,
                ev_cmd_wr, ev_srst_set, ev_srst_clr}));

   a_r3_alt_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (host_rd && host_blk) |=> !ev_stat_rd);

   a_r4_select_event: assert property (@(posedge clk) disable iff (!rst_n)
      (host_wr && !host_blk && host_addr == RA_DRV) |=> ev_sel_wr);

   a_r5_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_cmd_wr && !ev_cmd_err) |->
         (stat_q[ST_BSY] && !stat_q[ST_DRQ] && !stat_q[ST_DF] && err_q == 8'h00));

   a_r7_bytes_class: assert property (@(posedge clk) disable iff (!rst_n)
      ev_cmd_wr |-> ((xfer_class == 2'd0) == (xfer_bytes == '0)));

   a_r11_abort_flags: assert property (@(posedge clk) disable iff (!rst_n)
      ev_cmd_err |-> (ev_cmd_wr && err_q == ERR_ABORT && stat_q == STAT_ABORT));

   a_r13_srst_enter: assert property (@(posedge clk) disable iff (!rst_n)
      ev_srst_set |-> (srst_active && stat_q[ST_BSY]));

   a_r13_srst_leave: assert property (@(posedge clk) disable iff (!rst_n)
      ev_srst_clr |-> (!srst_active && err_q == ERR_DIAG && stat_q == STAT_IDLE));
endmodule

bind ata_taskfile_dec ata_tf_chk #(.SECTOR_BYTES(SECTOR_BYTES)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .host_rd     (host_rd),
   .host_wr     (host_wr),
   .host_blk    (host_blk),
   .host_addr   (host_addr),
   .ev_data_rd  (ev_data_rd),
   .ev_data_wr  (ev_data_wr),
   .ev_stat_rd  (ev_stat_rd),
   .ev_sel_wr   (ev_sel_wr),
   .ev_cmd_wr   (ev_cmd_wr),
   .ev_cmd_err  (ev_cmd_err),
   .ev_srst_set (ev_srst_set),
   .ev_srst_clr (ev_srst_clr),
   .stat_q      (stat_q),
   .err_q       (err_q),
   .srst_active (srst_active),
   .xfer_class  (xfer_class),
   .xfer_bytes  (xfer_bytes)
);

// File: tb/tb_ata_taskfile_dec.sv
`timescale 1ns/1ps
module tb_ata_taskfile_dec;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_rd = 1'b0, host_wr = 1'b0, host_blk = 1'b0;
   logic [2:0]  host_addr = '0;
   logic [15:0] host_wdata = '0;
   logic [15:0] host_rdata;
   logic        sm_data_load = 1'b0, sm_stat_we = 1'b0;
   logic [15:0] sm_data_word = '0;
   logic [7:0]  sm_stat_val = '0;
   logic [27:0] capacity = 28'h3A5C7E1;
   logic ev_data_rd, ev_data_wr, ev_stat_rd, ev_sel_wr;
   logic ev_cmd_wr, ev_cmd_err, ev_srst_set, ev_srst_clr;
   logic [1:0]  xfer_class;
   logic        dma_mem_wr, irq_disable, srst_active;
   logic [27:0] start_lba;
   logic [17:0] xfer_bytes;

   int checks = 0;
   int errors = 0;
   logic [7:0]  evs;
   logic [15:0] rv;

   always #2.5 clk = ~clk;

   ata_taskfile_dec dut (
      .clk(clk), .rst_n(rst_n), .host_rd(host_rd), .host_wr(host_wr),
      .host_blk(host_blk), .host_addr(host_addr), .host_wdata(host_wdata),
      .host_rdata(host_rdata), .sm_data_load(sm_data_load),
      .sm_data_word(sm_data_word), .sm_stat_we(sm_stat_we),
      .sm_stat_val(sm_stat_val), .capacity(capacity),
      .ev_data_rd(ev_data_rd), .ev_data_wr(ev_data_wr),
      .ev_stat_rd(ev_stat_rd), .ev_sel_wr(ev_sel_wr),
      .ev_cmd_wr(ev_cmd_wr), .ev_cmd_err(ev_cmd_err),
      .ev_srst_set(ev_srst_set), .ev_srst_clr(ev_srst_clr),
      .xfer_class(xfer_class), .dma_mem_wr(dma_mem_wr),
      .start_lba(start_lba), .xfer_bytes(xfer_bytes),
      .irq_disable(irq_disable), .srst_active(srst_active)
   );

   // event bits: 7 data_rd 6 data_wr 5 stat_rd 4 sel 3 cmd 2 cmd_err 1 srst_set 0 srst_clr
   localparam logic [7:0] E_DRD = 8'h80, E_DWR = 8'h40, E_SRD = 8'h20, E_SEL = 8'h10;
   localparam logic [7:0] E_CMD = 8'h08, E_ERR = 8'h04, E_SET = 8'h02, E_CLR = 8'h01;

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, got, exp);
      end
   endtask

   task automatic grab();
      evs = {ev_data_rd, ev_data_wr, ev_stat_rd, ev_sel_wr,
             ev_cmd_wr, ev_cmd_err, ev_srst_set, ev_srst_clr};
   endtask

   task automatic hwr(input logic b, input logic [2:0] a, input logic [15:0] d);
      @(negedge clk);
      host_wr = 1'b1; host_blk = b; host_addr = a; host_wdata = d;
      @(negedge clk);
      host_wr = 1'b0;
      grab();
   endtask

   task automatic hrd(input logic b, input logic [2:0] a, output logic [15:0] v);
      @(negedge clk);
      host_rd = 1'b1; host_blk = b; host_addr = a;
      #1 v = host_rdata;
      @(negedge clk);
      host_rd = 1'b0;
      grab();
   endtask

   task automatic setup_tf(input logic [7:0] cnt, input logic [7:0] sec,
                           input logic [7:0] cl, input logic [7:0] ch, input logic [7:0] drv);
      hwr(0, 3'd2, {8'h0, cnt});
      hwr(0, 3'd3, {8'h0, sec});
      hwr(0, 3'd4, {8'h0, cl});
      hwr(0, 3'd5, {8'h0, ch});
      hwr(0, 3'd6, {8'h0, drv});
   endtask

   task automatic t_reset();
      hrd(0, 3'd1, rv); chk("R1 error after reset", rv, 16'h0001);
      hrd(1, 3'd6, rv); chk("R1 status after reset", rv, 16'h0040);
      hrd(0, 3'd3, rv); chk("R1 sector after reset", rv, 16'h0000);
      hrd(0, 3'd6, rv); chk("R1 drive after reset", rv, 16'h0000);
      chk("R1 irq_disable", irq_disable, 0);
      chk("R1 srst_active", srst_active, 0);
   endtask

   task automatic t_features_select();
      hwr(0, 3'd1, 16'h0055);
      chk("R4 features no event", evs, 8'h00);
      hrd(0, 3'd1, rv); chk("R4 features ignored", rv, 16'h0001);
      hwr(0, 3'd6, 16'h00E5);
      chk("R4 select event", evs, E_SEL);
   endtask

   task automatic t_dma_read();
      setup_tf(8'h00, 8'h11, 8'h22, 8'h33, 8'hE5);
      hwr(0, 3'd7, 16'h00C8);
      chk("R5 cmd event", evs, E_CMD);
      chk("R6 dma class", xfer_class, 3);
      chk("R9 dma read-media dir", dma_mem_wr, 1);
      chk("R7 count zero bytes", xfer_bytes, 131072);
      chk("R8 start lba", start_lba, 28'h5332211);
      hrd(1, 3'd6, rv); chk("R5 busy status", rv, 16'h00C0);
      hrd(0, 3'd1, rv); chk("R5 error cleared", rv, 16'h0000);
   endtask

   task automatic t_sm_status_dma_write();
      @(negedge clk); sm_stat_we = 1'b1; sm_stat_val = 8'h58;
      @(negedge clk); sm_stat_we = 1'b0;
      hrd(1, 3'd6, rv); chk("R14 sequencer status", rv, 16'h0058);
      hwr(0, 3'd2, 16'h0003);
      hwr(0, 3'd7, 16'h00CA);
      chk("R6 dma write class", xfer_class, 3);
      chk("R9 dma write-media dir", dma_mem_wr, 0);
      chk("R7 three sectors", xfer_bytes, 1536);
      hrd(1, 3'd6, rv); chk("R5 drq df cleared", rv, 16'h00D0);
   endtask

   task automatic t_pio_classes();
      hwr(0, 3'd2, 16'h0001);
      hwr(0, 3'd7, 16'h0030);
      chk("R6 pio out class", xfer_class, 2);
      chk("R7 one sector", xfer_bytes, 512);
      hwr(0, 3'd2, 16'h0002);
      hwr(0, 3'd7, 16'h00C4);
      chk("R6 pio in class", xfer_class, 1);
      chk("R7 two sectors", xfer_bytes, 1024);
      hwr(0, 3'd2, 16'h00FF);
      hwr(0, 3'd7, 16'h00EC);
      chk("R6 identify class", xfer_class, 1);
      chk("R7 identify bytes", xfer_bytes, 512);
      hwr(0, 3'd7, 16'h00E7);
      chk("R6 non-data class", xfer_class, 0);
      chk("R7 non-data bytes", xfer_bytes, 0);
   endtask

   task automatic t_unknown();
      hwr(0, 3'd7, 16'h0055);
      chk("R11 abort events", evs, E_CMD | E_ERR);
      hrd(0, 3'd1, rv); chk("R11 abort error", rv, 16'h0004);
      hrd(1, 3'd6, rv); chk("R11 abort status", rv, 16'h0041);
      chk("R11 abort class", xfer_class, 0);
   endtask

   task automatic t_chs();
      hwr(0, 3'd6, 16'h00A0);
      hwr(0, 3'd2, 16'h0004);
      hwr(0, 3'd7, 16'h0020);
      chk("R10 chs rejected", evs, E_CMD | E_ERR);
      hrd(0, 3'd1, rv); chk("R10 chs error", rv, 16'h0004);
   endtask

   task automatic t_max_native();
      hwr(0, 3'd6, 16'h00E0);
      hwr(0, 3'd7, 16'h00F8);
      chk("R12 accepted", evs, E_CMD);
      hrd(0, 3'd3, rv); chk("R12 sector", rv, 16'h00E0);
      hrd(0, 3'd4, rv); chk("R12 cyl low", rv, 16'h00C7);
      hrd(0, 3'd5, rv); chk("R12 cyl high", rv, 16'h00A5);
      hrd(0, 3'd6, rv); chk("R12 head", rv, 16'h00E3);
   endtask

   task automatic t_data();
      hwr(0, 3'd0, 16'hBEEF);
      chk("R2 data write event", evs, E_DWR);
      hrd(0, 3'd0, rv);
      chk("R2 data readback", rv, 16'hBEEF);
      chk("R2 data read event", evs, E_DRD);
      @(negedge clk); sm_data_load = 1'b1; sm_data_word = 16'h1234;
      @(negedge clk); sm_data_load = 1'b0;
      hrd(0, 3'd0, rv); chk("R2 sequencer word", rv, 16'h1234);
   endtask

   task automatic t_status_reads();
      @(negedge clk); sm_stat_we = 1'b1; sm_stat_val = 8'h50;
      @(negedge clk); sm_stat_we = 1'b0;
      hrd(0, 3'd7, rv);
      chk("R3 status value", rv, 16'h0050);
      chk("R3 status event", evs, E_SRD);
      hrd(1, 3'd6, rv);
      chk("R3 alt value", rv, 16'h0050);
      chk("R3 alt no event", evs, 8'h00);
   endtask

   task automatic t_control();
      hwr(1, 3'd6, 16'h0002);
      chk("R13 nien latched", irq_disable, 1);
      chk("R13 no srst event", evs, 8'h00);
      hwr(1, 3'd6, 16'h0004);
      chk("R13 srst set event", evs, E_SET);
      chk("R13 srst active", srst_active, 1);
      chk("R13 nien cleared", irq_disable, 0);
      hrd(1, 3'd6, rv); chk("R13 busy in reset", rv[7], 1);
      hwr(1, 3'd6, 16'h0000);
      chk("R13 srst clear event", evs, E_CLR);
      chk("R13 srst released", srst_active, 0);
      hrd(0, 3'd1, rv); chk("R13 error restored", rv, 16'h0001);
      hrd(1, 3'd6, rv); chk("R13 status restored", rv, 16'h0040);
      hrd(0, 3'd3, rv); chk("R13 sector restored", rv, 16'h0000);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_features_select();
      t_dma_read();
      t_sm_status_dma_write();
      t_pio_classes();
      t_unknown();
      t_chs();
      t_max_native();
      t_data();
      t_status_reads();
      t_control();
      repeat (2) @(negedge clk);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule